// File: doc/BRIEF.md
# Split-Carry Machine Timer

This block keeps a 64-bit system time that advances by one on every clock while the count enable is high. It also holds a 64-bit compare value, and it raises a one-cycle machine timer interrupt when the time has reached that value. A 32-bit memory-mapped port reaches both values, one 32-bit half at a time. The full current time is also driven out continuously, so CSR logic or any other consumer can read it without a bus cycle.

For timing, the counter is built from two 32-bit halves. A registered carry runs from the low half to the high half. The comparator is built the same way: two 32-bit partial results are registered and then combined. The interrupt is single-shot. It fires once when the condition first holds and stays quiet until software writes the compare value again. Software arms the timer by writing a compare word, then waits for the pulse.

Top module: `mtmr_top`

## Requirements
- R1: After synchronous reset, the time output is 0, both compare words read 0, and the interrupt and acknowledge outputs are low.
- R2: While `count_en` is high and no time-low write is in progress, the low time word increases by one on every clock. While `count_en` is low, the time holds its value.
- R3: When the low word rolls over from 0xFFFFFFFF to 0, the high word increases by one a single clock later.
- R4: A bus write to a time word replaces that word at the write edge and takes priority over the increment.
- R5: The register offsets from the base 0xFFFFFF90 are 0x0 for time low, 0x4 for time high, 0x8 for compare low and 0xC for compare high. All four can be read and written.
- R6: Every request is answered by a one-cycle `ack_o` on the following cycle. For a read, `rdata_o` carries the addressed word in that same cycle.
- R7: Some accesses hit no register: those whose address bits above bit 3 differ from the base, and those whose bits [1:0] are not zero. Such writes change nothing, and such reads return 0.
- R8: The interrupt is a one-cycle pulse on `irq_o`. It appears two clocks after the 64-bit time first reaches or passes the compare value.
- R9: After a pulse, no further pulse occurs until a compare word is written, even while the condition keeps holding. No pulse occurs after reset until a compare word is written.
- R10: A write to either compare word re-arms the interrupt. If the condition holds right after the write, the pulse is visible two clocks after the write edge, and not earlier.
- R11: The comparison covers all 64 bits. A larger low word does not trigger the interrupt while the high time word is below the high compare word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| count_en | input | 1 | Time advance enable |
| req_i | input | 1 | Bus request strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| ack_o | output | 1 | Access acknowledge, one cycle after the request |
| rdata_o | output | DATA_W | Read data, valid with `ack_o` |
| time_o | output | 2*DATA_W | Current 64-bit time |
| irq_o | output | 1 | Single-shot timer interrupt |

## Verification
The interrupt path is exercised in four ways, and each shows a different fault:
- A compare value written below a frozen time shows whether the arm-then-settle delay gives exactly two cycles of latency.
- A compare value reached by counting pins the pulse to the time value seen at the pulse, which exposes an extra or missing pipeline stage.
- A case where the low word is larger but the high word is smaller shows whether the comparator ignores the high half.
- Writing the same compare value again shows whether re-arming works.

The counter is run for a fixed number of enabled cycles and then frozen across a low-word rollover, which separates a lost carry from a carry that arrives too early. Writes made while counting show whether a write wins over the increment. Accesses to unmapped and misaligned addresses are followed by reads of every register, to show that nothing was touched.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  // Register select, taken from address bits [3:2]; the order sets the offsets.
  typedef enum logic [1:0] {
    SEL_TIME_LO = 2'd0,
    SEL_TIME_HI = 2'd1,
    SEL_CMP_LO  = 2'd2,
    SEL_CMP_HI  = 2'd3
  } mtmr_sel_e;
endpackage

// File: rtl/mtmr_split_counter.sv
module mtmr_split_counter #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wdata,
  output logic [HALF_W-1:0] lo_o,
  output logic [HALF_W-1:0] hi_o
);
  logic [HALF_W-1:0] lo_q, hi_q;
  logic              carry_q;

  // Low half: a write wins over the increment; the carry is taken when the low half is all ones.
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q    <= '0;
      carry_q <= 1'b0;
    end else if (wr_lo) begin
      lo_q    <= wdata;
      carry_q <= 1'b0;
    end else if (en) begin
      lo_q    <= lo_q + HALF_W'(1);
      carry_q <= &lo_q;
    end else begin
      carry_q <= 1'b0;
    end
  end

  // High half: takes the registered carry one clock after the low half wraps.
  always_ff @(posedge clk) begin
    if (rst)        hi_q <= '0;
    else if (wr_hi) hi_q <= wdata;
    else            hi_q <= hi_q + HALF_W'(carry_q);
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  assert_lo_step_R2: assert property (@(posedge clk) disable iff (rst)
    (en && !wr_lo) |=> (lo_q == $past(lo_q) + HALF_W'(1)));
  assert_lo_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!en && !wr_lo) |=> $stable(lo_q));
  assert_hi_carry_R3: assert property (@(posedge clk) disable iff (rst)
    (carry_q && !wr_hi) |=> (hi_q == $past(hi_q) + HALF_W'(1)));
  assert_lo_write_R4: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> (lo_q == $past(wdata)));
endmodule

// File: rtl/mtmr_split_compare.sv
module mtmr_split_compare #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HALF_W-1:0] t_lo,
  input  logic [HALF_W-1:0] t_hi,
  input  logic [HALF_W-1:0] c_lo,
  input  logic [HALF_W-1:0] c_hi,
  output logic              match_o
);
  logic hi_gt_q, hi_eq_q, lo_ge_q;

  // Each half is compared on its own; the three partial results are registered.
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_gt_q <= 1'b0;
      hi_eq_q <= 1'b0;
      lo_ge_q <= 1'b0;
    end else begin
      hi_gt_q <= t_hi >  c_hi;
      hi_eq_q <= t_hi == c_hi;
      lo_ge_q <= t_lo >= c_lo;
    end
  end

  assign match_o = hi_gt_q | (hi_eq_q & lo_ge_q);

  assert_hi_dominates_R11: assert property (@(posedge clk) disable iff (rst)
    (t_hi < c_hi) |=> !match_o);
endmodule

// File: rtl/mtmr_oneshot.sv
module mtmr_oneshot (
  input  logic clk,
  input  logic rst,
  input  logic match_i,
  input  logic rearm_i,
  output logic irq_o
);
  logic armed_q, settle_q, irq_q;

  // A compare write arms the pulse and blanks one cycle while the partial compares refresh.
  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q  <= 1'b0;
      settle_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      settle_q <= rearm_i;
      irq_q    <= 1'b0;
      if (rearm_i) begin
        armed_q <= 1'b1;
      end else if (armed_q && !settle_q && match_i) begin
        irq_q   <= 1'b1;
        armed_q <= 1'b0;
      end
    end
  end

  assign irq_o = irq_q;

  assert_irq_single_R8: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(match_i));
  assert_no_early_R10: assert property (@(posedge clk) disable iff (rst)
    rearm_i |=> !irq_q);
  assert_disarmed_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !rearm_i) |=> !armed_q);
endmodule

// File: rtl/mtmr_top.sv
module mtmr_top #(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_FF90
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                count_en,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic                ack_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [2*DATA_W-1:0] time_o,
  output logic                irq_o
);
  import mtmr_pkg::*;

  localparam int TIME_W  = 2 * DATA_W;
  localparam int WIN_LSB = 4;

  logic              hit;
  mtmr_sel_e         sel;
  logic              wr_tlo, wr_thi, wr_clo, wr_chi;
  logic [DATA_W-1:0] t_lo, t_hi, cmp_lo_q, cmp_hi_q;
  logic              match;
  logic              ack_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;
  logic [TIME_W-1:0] time_w;

  // Address decode: 16-byte window at the base, word-aligned only.
  assign hit = (addr_i[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]) && (addr_i[1:0] == 2'b00);
  assign sel = mtmr_sel_e'(addr_i[3:2]);

  assign wr_tlo = req_i && we_i && hit && (sel == SEL_TIME_LO);
  assign wr_thi = req_i && we_i && hit && (sel == SEL_TIME_HI);
  assign wr_clo = req_i && we_i && hit && (sel == SEL_CMP_LO);
  assign wr_chi = req_i && we_i && hit && (sel == SEL_CMP_HI);

  mtmr_split_counter #(.HALF_W(DATA_W)) i_counter (
    .clk   (clk),
    .rst   (rst),
    .en    (count_en),
    .wr_lo (wr_tlo),
    .wr_hi (wr_thi),
    .wdata (wdata_i),
    .lo_o  (t_lo),
    .hi_o  (t_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_lo_q <= '0;
      cmp_hi_q <= '0;
    end else begin
      if (wr_clo) cmp_lo_q <= wdata_i;
      if (wr_chi) cmp_hi_q <= wdata_i;
    end
  end

  mtmr_split_compare #(.HALF_W(DATA_W)) i_compare (
    .clk     (clk),
    .rst     (rst),
    .t_lo    (t_lo),
    .t_hi    (t_hi),
    .c_lo    (cmp_lo_q),
    .c_hi    (cmp_hi_q),
    .match_o (match)
  );

  mtmr_oneshot i_oneshot (
    .clk     (clk),
    .rst     (rst),
    .match_i (match),
    .rearm_i (wr_clo | wr_chi),
    .irq_o   (irq_o)
  );

  always_comb begin
    case (sel)
      SEL_TIME_LO: rd_mux = t_lo;
      SEL_TIME_HI: rd_mux = t_hi;
      SEL_CMP_LO:  rd_mux = cmp_lo_q;
      SEL_CMP_HI:  rd_mux = cmp_hi_q;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= req_i;
      rdata_q <= (req_i && !we_i && hit) ? rd_mux : '0;
    end
  end

  assign time_w  = {t_hi, t_lo};
  assign time_o  = time_w;
  assign ack_o   = ack_q;
  assign rdata_o = rdata_q;

  assert_ack_follows_R6: assert property (@(posedge clk) disable iff (rst)
    req_i |=> ack_o);
  assert_ack_only_R6: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> !ack_o);
  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (req_i && !we_i && !hit) |=> (rdata_o == '0));
  assert_cmp_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(req_i && we_i && hit) |=> ($stable(cmp_lo_q) && $stable(cmp_hi_q)));
endmodule

// File: tb/test_mtmr_top.sv
module test_mtmr_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [31:0] BASE = 32'hFFFF_FF90;
  localparam logic [31:0] A_TLO = BASE + 32'h0;
  localparam logic [31:0] A_THI = BASE + 32'h4;
  localparam logic [31:0] A_CLO = BASE + 32'h8;
  localparam logic [31:0] A_CHI = BASE + 32'hC;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        count_en = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        ack;
  logic [31:0] rdata;
  logic [63:0] time_v;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  int irq_cnt = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  typedef struct {
    bit          is_rd;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #10 clk = ~clk;

  mtmr_top i_mtmr_top (
    .clk      (clk),
    .rst      (rst),
    .count_en (count_en),
    .req_i    (req),
    .we_i     (we),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .ack_o    (ack),
    .rdata_o  (rdata),
    .time_o   (time_v),
    .irq_o    (irq)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // Driver: queue the expected result, then issue a single-cycle request.
  task automatic bus(input bit wr, input logic [31:0] a, input logic [31:0] d,
                     input logic [31:0] exp, input string tag);
    sb_item_t it;
    it.is_rd = !wr;
    it.exp   = exp;
    it.tag   = tag;
    sb_q.push_back(it);
    @(negedge clk);
    req = 1'b1; we = wr; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    bus(1'b1, a, d, 32'h0, "write");
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string tag);
    bus(1'b0, a, 32'h0, exp, tag);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: every acknowledge pops one item; reads are compared.
  always @(negedge clk) begin
    if (!rst && ack) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R6 ack without request", 64'(ack), 64'h0);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        if (it.is_rd) check(rdata == it.exp, it.tag, 64'(rdata), 64'(it.exp));
      end
    end
    if (!rst && irq) irq_cnt++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      check(1'b0, "watchdog", 64'(cyc), 64'h0);
      report();
    end
  end

  initial begin
    int base;
    bit found;
    logic [63:0] t;

    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    // R1: reset state
    check(time_v == 64'h0, "R1 time after reset", time_v, 64'h0);
    check(irq == 1'b0, "R1 irq after reset", 64'(irq), 64'h0);
    check(ack == 1'b0, "R1 ack after reset", 64'(ack), 64'h0);
    rd(A_CLO, 32'h0, "R1 cmp lo reset");
    rd(A_CHI, 32'h0, "R1 cmp hi reset");
    // R9: condition holds (0 >= 0), but no pulse before a compare write
    wait_n(6);
    check(irq_cnt == 0, "R9 no pulse after reset", 64'(irq_cnt), 64'h0);

    // R5 / R10: compare below a frozen time; exact pulse timing
    wr(A_TLO, 32'd50);
    rd(A_TLO, 32'd50, "R5 time lo readback");
    rd(A_THI, 32'd0, "R5 time hi readback");
    wr(A_CLO, 32'd40);
    @(negedge clk);
    check(irq == 1'b0, "R10 no pulse one cycle after write", 64'(irq), 64'h0);
    @(negedge clk);
    check(irq == 1'b1, "R10 pulse two cycles after write", 64'(irq), 64'h1);
    @(negedge clk);
    check(irq == 1'b0, "R8 pulse lasts one cycle", 64'(irq), 64'h0);
    wait_n(10);
    check(irq_cnt == 1, "R9 single shot while condition holds", 64'(irq_cnt), 64'h1);
    rd(A_CLO, 32'd40, "R5 cmp lo readback");

    // R8: reaching the compare value by counting
    wr(A_TLO, 32'd0);
    wr(A_CLO, 32'd20);
    wait_n(3);
    check(irq_cnt == 1, "R8 no pulse below compare", 64'(irq_cnt), 64'h1);
    count_en = 1'b1;
    found = 1'b0;
    for (int i = 0; i < 40 && !found; i++) begin
      @(negedge clk);
      if (irq) found = 1'b1;
    end
    t = time_v;
    count_en = 1'b0;
    check(found && t == 64'd22, "R8 pulse two cycles after crossing", t, 64'd22);
    @(negedge clk);
    check(irq == 1'b0, "R8 crossing pulse one cycle", 64'(irq), 64'h0);

    // R11: low word larger, high word smaller
    base = irq_cnt;
    wr(A_TLO, 32'd100);
    wr(A_CHI, 32'd1);
    wr(A_CLO, 32'd5);
    wait_n(6);
    check(irq_cnt == base, "R11 high word blocks interrupt", 64'(irq_cnt), 64'(base));
    wr(A_THI, 32'd1);
    wait_n(4);
    check(irq_cnt == base + 1, "R11 pulse once high words equal", 64'(irq_cnt), 64'(base + 1));
    rd(A_THI, 32'd1, "R5 time hi write");
    rd(A_CHI, 32'd1, "R5 cmp hi readback");

    // R10: writing the same compare value again re-arms
    wr(A_CLO, 32'd5);
    wait_n(4);
    check(irq_cnt == base + 2, "R10 rewrite re-arms", 64'(irq_cnt), 64'(base + 2));

    // R2: count for a known number of cycles, then hold
    wr(A_TLO, 32'd1000);
    count_en = 1'b1;
    wait_n(17);
    count_en = 1'b0;
    check(time_v[31:0] == 32'd1017, "R2 seventeen increments", 64'(time_v[31:0]), 64'd1017);
    wait_n(5);
    check(time_v[31:0] == 32'd1017, "R2 hold while disabled", 64'(time_v[31:0]), 64'd1017);
    rd(A_TLO, 32'd1017, "R2 time lo readback");

    // R3: low-word rollover, high word one clock later
    wr(A_TLO, 32'hFFFF_FFFE);
    wr(A_THI, 32'd5);
    count_en = 1'b1;
    wait_n(2);
    count_en = 1'b0;
    check(time_v == {32'd5, 32'd0}, "R3 low wrapped, high not yet", time_v, {32'd5, 32'd0});
    @(negedge clk);
    check(time_v == {32'd6, 32'd0}, "R3 high one cycle later", time_v, {32'd6, 32'd0});
    rd(A_THI, 32'd6, "R3 time hi readback");

    // R4: writes while counting win over the increment
    count_en = 1'b1;
    wr(A_TLO, 32'h1234);
    count_en = 1'b0;
    check(time_v[31:0] == 32'h1234, "R4 lo write over increment", 64'(time_v[31:0]), 64'h1234);
    count_en = 1'b1;
    wr(A_THI, 32'd7);
    count_en = 1'b0;
    check(time_v == {32'd7, 32'h1236}, "R4 hi write while counting", time_v, {32'd7, 32'h1236});

    // R7: unmapped and misaligned accesses
    base = irq_cnt;
    wr(BASE + 32'h10, 32'hDEAD_BEEF);
    wr(32'h0000_0098, 32'd77);
    wr(BASE + 32'h9, 32'd88);
    wr(BASE + 32'h1, 32'd99);
    rd(BASE + 32'h10, 32'h0, "R7 read above window");
    rd(32'h0000_0098, 32'h0, "R7 read other base");
    rd(BASE + 32'h9, 32'h0, "R7 read misaligned");
    rd(A_CLO, 32'd5, "R7 cmp lo untouched");
    rd(A_CHI, 32'd1, "R7 cmp hi untouched");
    rd(A_TLO, 32'h1236, "R7 time lo untouched");
    rd(A_THI, 32'd7, "R7 time hi untouched");
    wait_n(4);
    check(irq_cnt == base, "R7 no re-arm from unmapped write", 64'(irq_cnt), 64'(base));

    wait_n(3);
    check(sb_q.size() == 0, "R6 every request acknowledged", 64'(sb_q.size()), 64'h0);
    done = 1'b1;
    report();
  end
endmodule